// File: doc/BRIEF.md
# Operand Sequence Test-Mode Trigger

This block sits beside a compute core and watches the operand word offered to the core each time a job is launched. The operand is looked at only in cycles where `start` is high. The block compares these sampled words with a fixed three-word key that is set by parameters at design time. When the three key words arrive exactly and in order, the block latches a test-mode level and gives a single-cycle completion pulse. The level then stays high until `clear` or reset.

A second, static path drives the same level. It takes an 8-bit configuration input, applies a parameter mask, and compares the result with a parameter key. While the masked bits equal that key, the test-mode level is high and no sequence is needed. This path holds no state of its own. The test-mode level is the OR of the two paths, and the core uses it to hand its datapath over to test work.

Top module: `seq_trigger`

## Requirements
- R1: After reset, `test_mode` and `match_pulse` are both low and the search starts from no words matched.
- R2: `operand` is sampled only in cycles where `start` is high. With `start` low, any operand value, including a key word, leaves the search progress and both outputs unchanged.
- R3: When the words KEY0, KEY1 and KEY2 are sampled in that order, `match_pulse` is high for exactly one cycle. That cycle follows the clock edge that samples KEY2, and `test_mode` is high from the same cycle.
- R4: A sampled word that breaks the order makes the search start again. If that word equals KEY0, it counts as the first matched word. Otherwise the progress goes back to none.
- R5: The latched sequence mode stays set until `clear` or reset. While it is set, further key sequences produce no `match_pulse`.
- R6: `clear` high at a clock edge drops the latched mode and returns the search to none matched. It takes priority over a sequence completing at the same edge, so that edge gives no pulse.
- R7: When `(cfg & CFG_MASK) == CFG_KEY` is sampled at an edge, `test_mode` is high in the following cycle. It does not depend on the sequence state or on `clear`, and it never produces `match_pulse`. When the masked value differs, this path drops its contribution in the following cycle.
- R8: `test_mode` is high exactly when the latched sequence mode is set or the registered configuration match is true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Job launch strobe; qualifies `operand` |
| operand | input | 32 | Operand word offered to the core |
| cfg | input | 8 | Configuration bits for the static key path |
| clear | input | 1 | Drops the latched sequence mode and restarts the search |
| test_mode | output | 1 | Test-mode level (sequence latch OR configuration match) |
| match_pulse | output | 1 | One-cycle pulse when the key sequence completes |

## Verification
A wrong progress value inside the recognizer stays hidden until a sequence tries to finish. It shows up as a missing or extra `match_pulse` one cycle after the third sampled word, so the bench sweeps every four-word string over the three key words plus a foreign word. It also places non-start cycles carrying key words between the sampled words. A lost or spurious latch shows at `test_mode` in the next cycle and remains visible there. A configuration-compare fault shows at `test_mode` one cycle after `cfg` changes, which the full sweep of `cfg` covers.

// File: rtl/seqtrig_pkg.sv
package seqtrig_pkg;

    localparam int SEQ_LEN = 3;
    localparam int PROG_W  = $clog2(SEQ_LEN);

    typedef logic [PROG_W-1:0] prog_t;

    typedef struct packed {
        prog_t prog;     // words matched so far
        logic  lock;     // latched sequence test mode
        logic  pulse;    // completion pulse
        logic  cfg_hit;  // registered configuration-key match
    } trig_state_t;

endpackage

// File: rtl/seqtrig_word_match.sv
module seqtrig_word_match #(
    parameter int                  W    = 32,
    parameter int                  LEN  = 3,
    parameter logic [LEN*W-1:0]    KEYS = '0
) (
    input  logic [W-1:0]   word,
    output logic [LEN-1:0] hit
);

    for (genvar g = 0; g < LEN; g++) begin : g_cmp
        localparam logic [W-1:0] KEY_G = KEYS[g*W +: W];
        assign hit[g] = (word == KEY_G);
    end

endmodule

// File: rtl/seqtrig_cfg_match.sv
module seqtrig_cfg_match #(
    parameter int                CW   = 8,
    parameter logic [CW-1:0]     MASK = '0,
    parameter logic [CW-1:0]     KEY  = '0
) (
    input  logic [CW-1:0] cfg,
    output logic          hit
);

    localparam logic [CW-1:0] KEY_M = KEY & MASK;

    assign hit = ((cfg & MASK) == KEY_M);

endmodule

// File: rtl/seqtrig_advance.sv
module seqtrig_advance
    import seqtrig_pkg::*;
#(
    parameter int LEN = SEQ_LEN
) (
    input  prog_t          prog,
    input  logic [LEN-1:0] hit,
    output prog_t          prog_nxt,
    output logic           done
);

    logic cur_hit;

    always_comb begin
        cur_hit = 1'b0;
        for (int i = 0; i < LEN; i++) begin
            if (prog == prog_t'(i)) cur_hit = hit[i];
        end
    end

    always_comb begin
        done     = 1'b0;
        prog_nxt = '0;
        if (cur_hit) begin
            if (prog == prog_t'(LEN-1)) begin
                done     = 1'b1;
                prog_nxt = '0;
            end else begin
                prog_nxt = prog + prog_t'(1);
            end
        end else if (hit[0]) begin
            prog_nxt = prog_t'(1);
        end
    end

endmodule

// File: rtl/seq_trigger.sv
module seq_trigger
    import seqtrig_pkg::*;
#(
    parameter int              W        = 32,
    parameter int              CW       = 8,
    parameter logic [W-1:0]    KEY0     = 32'h6B1D_04F2,
    parameter logic [W-1:0]    KEY1     = 32'hC93E_A717,
    parameter logic [W-1:0]    KEY2     = 32'h0F58_D2B6,
    parameter logic [CW-1:0]   CFG_MASK = 8'b1011_0100,
    parameter logic [CW-1:0]   CFG_KEY  = 8'b1001_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  operand,
    input  logic [CW-1:0] cfg,
    input  logic          clear,
    output logic          test_mode,
    output logic          match_pulse
);

    localparam logic [SEQ_LEN*W-1:0] KEY_VEC = {KEY2, KEY1, KEY0};

    trig_state_t           st_d, st_q;
    logic [SEQ_LEN-1:0]    word_hit;
    logic                  cfg_hit_w;
    prog_t                 prog_nxt;
    logic                  seq_done;
    logic                  lock_q;

    seqtrig_word_match #(
        .W    (W),
        .LEN  (SEQ_LEN),
        .KEYS (KEY_VEC)
    ) u_words (
        .word (operand),
        .hit  (word_hit)
    );

    seqtrig_cfg_match #(
        .CW   (CW),
        .MASK (CFG_MASK),
        .KEY  (CFG_KEY)
    ) u_cfg (
        .cfg  (cfg),
        .hit  (cfg_hit_w)
    );

    seqtrig_advance #(
        .LEN (SEQ_LEN)
    ) u_adv (
        .prog     (st_q.prog),
        .hit      (word_hit),
        .prog_nxt (prog_nxt),
        .done     (seq_done)
    );

    always_comb begin
        st_d         = st_q;
        st_d.pulse   = 1'b0;
        st_d.cfg_hit = cfg_hit_w;
        if (clear) begin
            st_d.prog = '0;
            st_d.lock = 1'b0;
        end else if (start && !st_q.lock) begin
            st_d.prog = prog_nxt;
            if (seq_done) begin
                st_d.lock  = 1'b1;
                st_d.pulse = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_q      = st_q.lock;
    assign test_mode   = st_q.lock | st_q.cfg_hit;
    assign match_pulse = st_q.pulse;

endmodule

// File: rtl/seq_trigger_chk.sv
module seq_trigger_chk #(
    parameter int              W        = 32,
    parameter int              CW       = 8,
    parameter logic [W-1:0]    KEY2     = '0,
    parameter logic [CW-1:0]   CFG_MASK = '0,
    parameter logic [CW-1:0]   CFG_KEY  = '0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [W-1:0]  operand,
    input logic [CW-1:0] cfg,
    input logic          clear,
    input logic          test_mode,
    input logic          match_pulse,
    input logic          lock
);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |=> !match_pulse); // R3

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> ($past(start) && $past(operand) == KEY2 && !$past(clear))); // R3

    AST_PULSE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> test_mode); // R3

    AST_NO_START_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !match_pulse); // R2

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !clear) |=> lock); // R5

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!lock && !match_pulse)); // R6

    AST_CFG_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg & CFG_MASK) == (CFG_KEY & CFG_MASK)) |=> test_mode); // R7

    AST_MODE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock && (cfg & CFG_MASK) != (CFG_KEY & CFG_MASK)) |=> (test_mode == lock)); // R8

endmodule

bind seq_trigger seq_trigger_chk #(
    .W        (W),
    .CW       (CW),
    .KEY2     (KEY2),
    .CFG_MASK (CFG_MASK),
    .CFG_KEY  (CFG_KEY)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .operand     (operand),
    .cfg         (cfg),
    .clear       (clear),
    .test_mode   (test_mode),
    .match_pulse (match_pulse),
    .lock        (lock_q)
);

// File: tb/sim_seq_trigger.sv
module sim_seq_trigger;

    localparam logic [31:0] K0    = 32'h6B1D_04F2;
    localparam logic [31:0] K1    = 32'hC93E_A717;
    localparam logic [31:0] K2    = 32'h0F58_D2B6;
    localparam logic [31:0] KX    = 32'h1234_5678;
    localparam logic [7:0]  CMASK = 8'b1011_0100;
    localparam logic [7:0]  CKEY  = 8'b1001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        clear = 1'b0;
    logic [31:0] operand = '0;
    logic [7:0]  cfg = '0;
    logic        test_mode, match_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    seq_trigger u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .operand     (operand),
        .cfg         (cfg),
        .clear       (clear),
        .test_mode   (test_mode),
        .match_pulse (match_pulse)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] wsel(int i);
        case (i)
            0:       return K0;
            1:       return K1;
            2:       return K2;
            default: return KX;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // one cycle of stimulus, then check outputs one cycle later
    task automatic cyc(input logic s, input logic [31:0] w, input logic c,
                       input string req, input logic exp_p, input logic exp_m);
        @(negedge clk);
        start = s; operand = w; clear = c;
        @(negedge clk);
        start = 1'b0; clear = 1'b0;
        chk(req, "match_pulse", match_pulse, exp_p);
        chk(req, "test_mode", test_mode, exp_m);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "match_pulse in reset", match_pulse, 1'b0);
        chk("R1", "test_mode in reset", test_mode, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "match_pulse after reset", match_pulse, 1'b0);
        chk("R1", "test_mode after reset", test_mode, 1'b0);
        // R1: search starts empty: K1,K2 alone do not complete
        cyc(1'b1, K1, 1'b0, "R1", 1'b0, 1'b0);
        cyc(1'b1, K2, 1'b0, "R1", 1'b0, 1'b0);

        // R3 R4 R2: all four-word strings over {K0,K1,K2,X}, gaps carry key words
        for (int n = 0; n < 256; n++) begin
            int a [4];
            logic m3, m4, locked;
            a[0] = n % 4; a[1] = (n / 4) % 4; a[2] = (n / 16) % 4; a[3] = (n / 64) % 4;
            m3 = (a[0] == 0) && (a[1] == 1) && (a[2] == 2);
            m4 = !m3 && (a[1] == 0) && (a[2] == 1) && (a[3] == 2);
            cyc(1'b0, KX, 1'b1, "R6", 1'b0, 1'b0);
            locked = 1'b0;
            for (int k = 0; k < 4; k++) begin
                logic ep;
                ep = (k == 2 && m3) || (k == 3 && m4);
                locked = locked | ep;
                cyc(1'b1, wsel(a[k]), 1'b0, "R3_R4", ep, locked);
                // R2: non-start cycle with the next key word on the bus
                cyc(1'b0, wsel((k + 1) % 3), 1'b0, "R2", 1'b0, locked);
            end
        end

        // R4: restart across overlapping prefix
        cyc(1'b0, KX, 1'b1, "R4", 1'b0, 1'b0);
        cyc(1'b1, K0, 1'b0, "R4", 1'b0, 1'b0);
        cyc(1'b1, K1, 1'b0, "R4", 1'b0, 1'b0);
        cyc(1'b1, K0, 1'b0, "R4", 1'b0, 1'b0);
        cyc(1'b1, K1, 1'b0, "R4", 1'b0, 1'b0);
        cyc(1'b1, K2, 1'b0, "R4", 1'b1, 1'b1);

        // R5: locked, another full sequence gives no pulse, mode holds
        cyc(1'b1, K0, 1'b0, "R5", 1'b0, 1'b1);
        cyc(1'b1, K1, 1'b0, "R5", 1'b0, 1'b1);
        cyc(1'b1, K2, 1'b0, "R5", 1'b0, 1'b1);
        repeat (5) cyc(1'b0, KX, 1'b0, "R5", 1'b0, 1'b1);

        // R6: clear drops lock; clear wins over a completing word
        cyc(1'b0, KX, 1'b1, "R6", 1'b0, 1'b0);
        cyc(1'b1, K0, 1'b0, "R6", 1'b0, 1'b0);
        cyc(1'b1, K1, 1'b0, "R6", 1'b0, 1'b0);
        cyc(1'b1, K2, 1'b1, "R6", 1'b0, 1'b0);
        cyc(1'b1, K2, 1'b0, "R6", 1'b0, 1'b0);

        // R7 R8: full configuration sweep with the sequence latch clear
        for (int c = 0; c < 256; c++) begin
            logic eh;
            eh = ((8'(c) & CMASK) == CKEY);
            @(negedge clk);
            cfg = 8'(c);
            @(negedge clk);
            chk("R7", "test_mode cfg sweep", test_mode, eh);
            chk("R7", "match_pulse cfg sweep", match_pulse, 1'b0);
        end

        // R7: cfg path ignores clear; R8: OR of both sources
        @(negedge clk); cfg = CKEY | 8'b0100_1011;
        @(negedge clk);
        chk("R7", "cfg key with unmasked bits set", test_mode, 1'b1);
        cyc(1'b0, KX, 1'b1, "R7", 1'b0, 1'b1);
        cyc(1'b1, K0, 1'b0, "R8", 1'b0, 1'b1);
        cyc(1'b1, K1, 1'b0, "R8", 1'b0, 1'b1);
        cyc(1'b1, K2, 1'b0, "R8", 1'b1, 1'b1);
        @(negedge clk); cfg = 8'h00;
        @(negedge clk);
        chk("R8", "lock alone holds mode", test_mode, 1'b1);
        cyc(1'b0, KX, 1'b1, "R8", 1'b0, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule